// File: doc/BRIEF.md
# Single-Beat Block Copy DMA Channel

This block is one DMA channel that copies a block of elements from one memory-mapped region to another. It drives a simple request/grant master port and targets static-memory-style devices that cannot take bursts. Such targets include register-mapped peripherals and programmable logic where a read can have side effects. Each source read is exactly one bus access. The channel never reads ahead, so it never touches the address after the last source element.

Software sets up the channel through a small write port with four slots: source address, destination address, a control word and a configuration word. Bit 0 of the configuration word starts the channel. While it runs, the channel performs one read and then one write for each element. When the count runs out, or when the bus returns an error, it clears its enable and raises a sticky status flag.

Top module: `blkcopy_dma`

## Requirements
- R1: After reset, `ch_en`, `xfer_done`, `xfer_err` and `m_req` are 0 and `remaining` is 0.
- R2: Each source read is a single bus access (one request held until one grant). Every granted read is followed at once by a write request, so the accesses strictly alternate read, write, read, write.
- R3: A transfer of N elements issues exactly N reads and N writes. No read goes past the last source element, and no access follows the final write.
- R4: The address step is 1, 2 or 4 bytes for width codes 0, 1 and 2; code 3 also steps by 4. Source and destination use their own codes. An address advances after each of its granted accesses only when its increment flag is set. Addresses keep their advanced value after a transfer ends.
- R5: The data of each write equals the data returned by the read just before it.
- R6: Control word layout: bits [11:0] hold the element count, [13:12] the source width code, [15:14] the destination width code, bit 16 the source increment flag and bit 17 the destination increment flag. The count can only go down while the channel runs.
- R7: Writing slot 3 (slot 0 source, 1 destination, 2 control) with bit 0 set while idle makes `ch_en` read 1 after the next clock. `m_size` carries the width code of the access in progress.
- R8: One cycle after the last write is granted, `ch_en` is 0, `xfer_done` is 1, `remaining` is 0 and `m_req` is 0. `xfer_done` stays set until the next start, which clears it. Done and error are never set together.
- R9: A start with count zero sets `xfer_done` on the next cycle and makes no bus access.
- R10: A grant with `m_err` set stops the channel. `ch_en` drops, `xfer_err` rises, no further access is made, and `remaining` shows the elements whose writes never finished.
- R11: Writes to any slot while `ch_en` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_sel | input | 2 | Setup slot: 0 source, 1 destination, 2 control, 3 configuration |
| cfg_wdata | input | DW | Setup write data |
| ch_en | output | 1 | Channel enabled (transfer running) |
| xfer_done | output | 1 | Sticky completion flag |
| xfer_err | output | 1 | Sticky bus error flag |
| remaining | output | CNT_W | Elements still to move |
| m_req | output | 1 | Bus request, held until granted |
| m_we | output | 1 | 1 write, 0 read |
| m_addr | output | AW | Byte address of the access |
| m_size | output | 2 | Width code of the access |
| m_wdata | output | DW | Write data |
| m_gnt | input | 1 | Access completed this cycle |
| m_rdata | input | DW | Read data, valid with grant |
| m_err | input | 1 | Error response, valid with grant |

## Verification
The transfer is run with 32-, 16- and 8-bit elements, with mixed source and destination widths, and with a fixed source or fixed destination address. It is also run with grant latencies from zero to three cycles and with counts of one and of several elements. The address patterns show whether each step is chosen by its own width code and increment flag. The latencies show whether the request is held without extra beats. The one-element and multi-element counts expose any read past the end of the buffer. Error responses on a read and on a write show whether the stop point and the remaining count are exact. A zero count, a restart and setup writes made during a transfer cover the idle-path and ignored-write cases.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_CFG  = 2'd3;

  // byte step for a width code; the spare code behaves as a full word
  function automatic logic [2:0] step_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/bcd_addr_ctr.sv
module bcd_addr_ctr
  import bcd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic          inc_en,
  input  logic [1:0]    wcode,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (adv && inc_en) begin
      addr <= addr + AW'(step_bytes(wcode));
    end
  end

endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcd_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_init,
  input  logic             gnt,
  input  logic             bus_err,
  input  logic [DW-1:0]    rdata,
  output seq_state_e       state,
  output logic             rd_fire,
  output logic             wr_fire,
  output logic [CNT_W-1:0] cnt_left,
  output logic             en,
  output logic             done,
  output logic             err,
  output logic [DW-1:0]    hold
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign rd_fire = (state == ST_RD) && gnt && !bus_err;
  assign wr_fire = (state == ST_WR) && gnt && !bus_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt_left <= '0;
      en       <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            err      <= 1'b0;
            cnt_left <= cnt_init;
            if (cnt_init == '0) begin
              done <= 1'b1;
            end else begin
              done  <= 1'b0;
              en    <= 1'b1;
              state <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (gnt) begin
            if (bus_err) begin
              err   <= 1'b1;
              en    <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (gnt) begin
            if (bus_err) begin
              err   <= 1'b1;
              en    <= 1'b0;
              state <= ST_IDLE;
            end else begin
              cnt_left <= cnt_left - ONE;
              if (cnt_left == ONE) begin
                done  <= 1'b1;
                en    <= 1'b0;
                state <= ST_IDLE;
              end else begin
                state <= ST_RD;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold <= '0;
    end else if (rd_fire) begin
      hold <= rdata;
    end
  end

endmodule

// File: rtl/blkcopy_dma.sv
module blkcopy_dma
  import bcd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic             ch_en,
  output logic             xfer_done,
  output logic             xfer_err,
  output logic [CNT_W-1:0] remaining,
  output logic             m_req,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [1:0]       m_size,
  output logic [DW-1:0]    m_wdata,
  input  logic             m_gnt,
  input  logic [DW-1:0]    m_rdata,
  input  logic             m_err
);

  localparam int SWC_LSB  = CNT_W;
  localparam int DWC_LSB  = CNT_W + 2;
  localparam int SINC_BIT = CNT_W + 4;
  localparam int DINC_BIT = CNT_W + 5;
  localparam int CTRL_W   = CNT_W + 6;
  localparam int NPORT    = 2;

  logic              wr_ok, start_go;
  logic [CTRL_W-1:0] ctrl_q;
  seq_state_e        state;
  logic              rd_fire, wr_fire, en;
  logic [CNT_W-1:0]  cnt_left;
  logic [DW-1:0]     hold;
  logic              done_q, err_q;

  logic [NPORT-1:0]    ld_v, adv_v, inc_v;
  logic [2*NPORT-1:0]  wc_v;
  logic [NPORT*AW-1:0] addr_v;
  logic [AW-1:0]       src_addr, dst_addr;

  assign wr_ok    = cfg_we && !en;
  assign start_go = wr_ok && (cfg_sel == SEL_CFG) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ok && (cfg_sel == SEL_CTRL)) begin
      ctrl_q <= cfg_wdata[CTRL_W-1:0];
    end
  end

  // port 0 follows the source, port 1 the destination
  assign ld_v[0]  = wr_ok && (cfg_sel == SEL_SRC);
  assign ld_v[1]  = wr_ok && (cfg_sel == SEL_DST);
  assign adv_v[0] = rd_fire;
  assign adv_v[1] = wr_fire;
  assign inc_v[0] = ctrl_q[SINC_BIT];
  assign inc_v[1] = ctrl_q[DINC_BIT];
  assign wc_v[1:0] = ctrl_q[SWC_LSB +: 2];
  assign wc_v[3:2] = ctrl_q[DWC_LSB +: 2];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    bcd_addr_ctr #(.AW(AW)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (ld_v[g]),
      .load_val (cfg_wdata[AW-1:0]),
      .adv      (adv_v[g]),
      .inc_en   (inc_v[g]),
      .wcode    (wc_v[2*g +: 2]),
      .addr     (addr_v[g*AW +: AW])
    );
  end

  assign src_addr = addr_v[0 +: AW];
  assign dst_addr = addr_v[AW +: AW];

  bcd_seq #(.CNT_W(CNT_W), .DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start_go),
    .cnt_init (ctrl_q[CNT_W-1:0]),
    .gnt      (m_gnt),
    .bus_err  (m_err),
    .rdata    (m_rdata),
    .state    (state),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .cnt_left (cnt_left),
    .en       (en),
    .done     (done_q),
    .err      (err_q),
    .hold     (hold)
  );

  assign m_req     = (state != ST_IDLE);
  assign m_we      = (state == ST_WR);
  assign m_addr    = m_we ? dst_addr : src_addr;
  assign m_size    = m_we ? wc_v[3:2] : wc_v[1:0];
  assign m_wdata   = hold;
  assign ch_en     = en;
  assign xfer_done = done_q;
  assign xfer_err  = err_q;
  assign remaining = cnt_left;

endmodule

// File: rtl/bcd_chk.sv
module bcd_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ch_en,
  input logic             xfer_done,
  input logic             xfer_err,
  input logic [CNT_W-1:0] remaining,
  input logic             m_req,
  input logic             m_we,
  input logic [AW-1:0]    m_addr,
  input logic [DW-1:0]    m_wdata,
  input logic             m_gnt,
  input logic [DW-1:0]    m_rdata,
  input logic             m_err
);

  AST_REQ_HELD_TO_GNT: assert property (@(posedge clk) disable iff (rst)
    m_req && !m_gnt |=> m_req && $stable(m_addr) && $stable(m_we)); // R2

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    m_req && m_gnt && !m_we && !m_err |=> m_req && m_we); // R2

  AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    m_req && m_gnt && !m_we && !m_err |=> m_wdata == $past(m_rdata)); // R5

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !ch_en |-> !m_req); // R9

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    m_req && m_gnt && m_err |=> !ch_en && xfer_err && !m_req); // R10

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(xfer_done && xfer_err)); // R8

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    ch_en |=> remaining <= $past(remaining)); // R6

endmodule

bind blkcopy_dma bcd_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ch_en     (ch_en),
  .xfer_done (xfer_done),
  .xfer_err  (xfer_err),
  .remaining (remaining),
  .m_req     (m_req),
  .m_we      (m_we),
  .m_addr    (m_addr),
  .m_wdata   (m_wdata),
  .m_gnt     (m_gnt),
  .m_rdata   (m_rdata),
  .m_err     (m_err)
);

// File: tb/test_blkcopy_dma.sv
module test_blkcopy_dma;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CNT_W = 12;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [11:0] cnt;
    logic [1:0]  sw;
    logic [1:0]  dw;
    logic        si;
    logic        di;
    logic [3:0]  lat;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000, 32'h2000, 12'd4, 2'd2, 2'd2, 1'b1, 1'b1, 4'd0},
    '{32'h0100, 32'h0300, 12'd3, 2'd1, 2'd1, 1'b1, 1'b1, 4'd2},
    '{32'h0040, 32'h0080, 12'd5, 2'd0, 2'd0, 1'b1, 1'b1, 4'd1},
    '{32'h0500, 32'h0600, 12'd3, 2'd2, 2'd2, 1'b0, 1'b1, 4'd0},
    '{32'h0700, 32'h0800, 12'd4, 2'd2, 2'd0, 1'b1, 1'b0, 4'd3},
    '{32'h0900, 32'h0A00, 12'd1, 2'd3, 2'd1, 1'b1, 1'b1, 4'd0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [DW-1:0]    cfg_wdata = '0;
  logic             ch_en, xfer_done, xfer_err;
  logic [CNT_W-1:0] remaining;
  logic             m_req, m_we;
  logic [AW-1:0]    m_addr;
  logic [1:0]       m_size;
  logic [DW-1:0]    m_wdata;
  logic             m_gnt = 1'b0;
  logic [DW-1:0]    m_rdata = '0;
  logic             m_err = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  blkcopy_dma #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) i_blkcopy_dma (
    .clk, .rst, .cfg_we, .cfg_sel, .cfg_wdata,
    .ch_en, .xfer_done, .xfer_err, .remaining,
    .m_req, .m_we, .m_addr, .m_size, .m_wdata,
    .m_gnt, .m_rdata, .m_err
  );

  // target model and access log
  logic        lg_we   [0:63];
  logic [31:0] lg_addr [0:63];
  logic [31:0] lg_data [0:63];
  logic [1:0]  lg_size [0:63];
  int log_n = 0;
  int lat_cfg = 0;
  int wait_n = 0;
  int err_idx = -1;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h1234_5678;
  endfunction

  function automatic int step_of(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      m_gnt = 1'b0; m_err = 1'b0; wait_n = 0;
    end else if (m_gnt) begin
      m_gnt = 1'b0; m_err = 1'b0; wait_n = 0;
    end else if (m_req) begin
      if (wait_n >= lat_cfg) begin
        m_gnt   = 1'b1;
        m_err   = (log_n == err_idx);
        m_rdata = m_we ? 32'h0 : pat(m_addr);
        if (log_n < 64) begin
          lg_we[log_n]   = m_we;
          lg_addr[log_n] = m_addr;
          lg_data[log_n] = m_we ? m_wdata : m_rdata;
          lg_size[log_n] = m_size;
        end
        log_n++;
      end else begin
        wait_n++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_ctrl(input vec_t v);
    return {14'd0, v.di, v.si, v.dw, v.sw, v.cnt};
  endfunction

  task automatic start_vec(input vec_t v);
    cfg_write(2'd0, v.src);
    cfg_write(2'd1, v.dst);
    cfg_write(2'd2, mk_ctrl(v));
    lat_cfg = int'(v.lat);
    log_n = 0;
    cfg_write(2'd3, 32'h1);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && ch_en; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_run(input vec_t v, input logic [31:0] src0);
    int n = int'(v.cnt);
    chk("R8 ch_en after end", ch_en, 0);
    chk("R8 done after end", xfer_done, 1);
    chk("R8 err clear", xfer_err, 0);
    chk("R8 remaining zero", remaining, 0);
    chk("R8 m_req low", m_req, 0);
    chk("R3 R6 access count", log_n, 2 * n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] ra = src0 + (v.si ? 32'(i * step_of(v.sw)) : 32'd0);
      logic [31:0] wa = v.dst + (v.di ? 32'(i * step_of(v.dw)) : 32'd0);
      chk("R2 read slot", lg_we[2*i], 0);
      chk("R3 R4 read addr", lg_addr[2*i], ra);
      chk("R7 read size", lg_size[2*i], v.sw);
      chk("R2 write slot", lg_we[2*i+1], 1);
      chk("R4 write addr", lg_addr[2*i+1], wa);
      chk("R7 write size", lg_size[2*i+1], v.dw);
      chk("R5 write data", lg_data[2*i+1], pat(ra));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ch_en", ch_en, 0);
    chk("R1 done", xfer_done, 0);
    chk("R1 err", xfer_err, 0);
    chk("R1 m_req", m_req, 0);
    chk("R1 remaining", remaining, 0);

    // main table
    for (int v = 0; v < NVEC; v++) begin
      start_vec(VECS[v]);
      chk("R7 ch_en after start", ch_en, 1);
      chk("R8 done cleared by start", xfer_done, 0);
      wait_idle();
      check_run(VECS[v], VECS[v].src);
    end

    // zero count
    cfg_write(2'd2, 32'h0003_2000);
    log_n = 0;
    cfg_write(2'd3, 32'h1);
    chk("R9 done at once", xfer_done, 1);
    chk("R9 not enabled", ch_en, 0);
    repeat (3) @(negedge clk);
    chk("R9 no access", log_n, 0);

    // error on read of element 2 of 5
    err_idx = 4;
    start_vec('{32'h1000, 32'h2000, 12'd5, 2'd2, 2'd2, 1'b1, 1'b1, 4'd1});
    wait_idle();
    chk("R10 err flag read", xfer_err, 1);
    chk("R10 done low read", xfer_done, 0);
    chk("R10 en low read", ch_en, 0);
    chk("R10 remaining read", remaining, 3);
    chk("R10 no access after read err", log_n, 5);

    // error on write of element 0 of 3
    err_idx = 1;
    start_vec('{32'h1000, 32'h2000, 12'd3, 2'd2, 2'd2, 1'b1, 1'b1, 4'd0});
    wait_idle();
    chk("R10 err flag write", xfer_err, 1);
    chk("R10 remaining write", remaining, 3);
    chk("R10 no access after write err", log_n, 2);
    err_idx = -1;

    // setup writes while running are ignored
    start_vec('{32'h3000, 32'h4000, 12'd3, 2'd2, 2'd2, 1'b1, 1'b1, 4'd3});
    cfg_write(2'd0, 32'h0000_FFF0);
    cfg_write(2'd2, 32'h0003_A009);
    cfg_write(2'd3, 32'h1);
    wait_idle();
    check_run('{32'h3000, 32'h4000, 12'd3, 2'd2, 2'd2, 1'b1, 1'b1, 4'd3}, 32'h3000);
    lat_cfg = 0;
    log_n = 0;
    cfg_write(2'd3, 32'h1);
    wait_idle();
    chk("R11 count kept", log_n, 6);
    chk("R4 R11 source persists", lg_addr[0], 32'h300C);
    chk("R4 dest persists", lg_addr[1], 32'h400C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule